// File: doc/BRIEF.md
# Write-Merging Line Buffer Pool

The pool sits between a word-addressed requester and a slower memory back end. It holds four lines of sixteen 32-bit words. Each line is claimed on demand, either as a prefetch line that a read miss fills from memory, or as a merge line that collects byte-strobed writes. A write is acknowledged as soon as it is stored in a line, so the requester does not wait for memory. Several writes to the same line collapse into one later burst, and reads that hit a buffered line are answered without going to memory.

Dirty lines go back to memory when their buffer is needed for another line, or when the pool is switched off. A flush sends only the words that carry written bytes, in ascending address order. Clearing the enable input first drains and empties the pool. After that, every request is passed straight to the back end, and `flush_done` shows that the pool is empty and in pass-through mode.

Top module: `wmb_pool`

## Requirements
- R1: With the pool enabled, a write whose line is buffered, or which can claim a clean or free line, is acknowledged exactly one cycle after it is presented. The back end sees no access. `req_ack` is a single-cycle pulse.
- R2: Writes to a buffered line merge byte by byte. Strobe bit k selects bits 8k+7..8k. Lanes that were not selected keep their earlier content. No back-end write happens until the line is flushed.
- R3: A read that hits a line filled from memory returns the word one cycle after it is presented, with no back-end access.
- R4: A read miss loads all 16 words of the line (address = line tag concatenated with the word index, index 0 to 15 ascending) before it answers. With an always-ready back end, the answer comes 18 cycles after the request.
- R5: A read that hits a partially written line answers after one back-end read. Strobed bytes come from the line and the other bytes come from memory. With an always-ready back end this takes 2 cycles.
- R6: A new line takes the lowest-numbered free buffer without any back-end traffic. When no buffer is free, it takes the least recently used buffer, where a hit or an allocation counts as a use. A dirty victim is written back before it is reused.
- R7: A flush writes only the words whose strobes are nonzero, in strictly ascending address order, and passes those strobes to the back end.
- R8: After the enable is cleared, all dirty lines are written back and every line is invalidated. `flush_done` is high exactly when the enable is low and no line is valid.
- R9: With the pool disabled and empty, each request goes directly to the back end. Writes update memory before the acknowledge, and reads return memory data. With an always-ready back end the acknowledge comes 2 cycles after the request.
- R10: After reset no line is valid, `req_ack` and `mem_valid` are low, and `flush_done` is low while the enable is high.
- R11: A back-end request held while `mem_ready` is low keeps its address, direction and strobes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Pool enable; low drains the pool and then passes requests through |
| req_valid | input | 1 | Request present; held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address; the low 4 bits select the word in a line |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte-lane strobes for writes |
| req_ack | output | 1 | One-cycle acknowledge |
| req_rdata | output | 32 | Read data, valid with `req_ack` |
| mem_valid | output | 1 | Back-end request |
| mem_write | output | 1 | Back-end direction, 1 = write |
| mem_addr | output | AW | Back-end word address |
| mem_wdata | output | 32 | Back-end write data |
| mem_strb | output | 4 | Back-end byte strobes (zero on reads) |
| mem_ready | input | 1 | Back end accepts the request this cycle |
| mem_rdata | input | 32 | Back-end read data, valid when a read is accepted |
| flush_done | output | 1 | Pool disabled and empty |

## Verification
The bench presents every request on a falling edge and counts falling edges until `req_ack` appears. With an always-ready back end, some latencies are fixed and the bench compares the count exactly:
- buffered writes and read hits on filled lines: 1 cycle;
- reads of partly written lines: 2 cycles;
- pass-through requests: 2 cycles;
- line fills: 18 cycles.

Back-end effects are measured by counting accepted beats in a memory model around each request. This shows that merged writes stay local, that a fill reads 16 words, and that an eviction writes exactly the strobed words. The final sweep throttles `mem_ready`, so latency varies. There the bench checks only data, against a flat reference memory computed with masks, and compares all of memory after the last drain.

// File: rtl/wmb_pkg.sv
package wmb_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_FILL,
    ST_PEEK,
    ST_PASS,
    ST_ACK
  } state_e;

  // Overlay the selected byte lanes of upd onto base.
  function automatic word_t merge_lanes(word_t base, word_t upd, lane_t sel);
    word_t r;
    r = base;
    for (int l = 0; l < LANES; l++) begin
      if (sel[l]) r[8*l +: 8] = upd[8*l +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/wmb_store.sv
module wmb_store
  import wmb_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int WORDS = 16,
  parameter int BW    = 2,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          merge_en,
  input  logic          fill_en,
  input  logic [BW-1:0] wr_buf,
  input  logic [IW-1:0] wr_idx,
  input  word_t         wr_data,
  input  lane_t         wr_strb,
  input  logic          clr_en,
  input  logic [BW-1:0] clr_buf,
  input  logic [BW-1:0] rd_buf,
  input  logic [IW-1:0] rd_idx,
  output word_t         rd_data,
  output lane_t         rd_strb
);

  word_t data_q [NBUF][WORDS];
  lane_t strb_q [NBUF][WORDS];

  always_ff @(posedge clk) begin
    if (merge_en)
      data_q[wr_buf][wr_idx] <= merge_lanes(data_q[wr_buf][wr_idx], wr_data, wr_strb);
    else if (fill_en)
      data_q[wr_buf][wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBUF; b++)
        for (int w = 0; w < WORDS; w++)
          strb_q[b][w] <= '0;
    end else begin
      for (int b = 0; b < NBUF; b++) begin
        for (int w = 0; w < WORDS; w++) begin
          if (clr_en && clr_buf == BW'(b))
            strb_q[b][w] <= '0;
          if (merge_en && wr_buf == BW'(b) && wr_idx == IW'(w))
            strb_q[b][w] <= ((clr_en && clr_buf == BW'(b)) ? lane_t'(0) : strb_q[b][w]) | wr_strb;
        end
      end
    end
  end

  assign rd_data = data_q[rd_buf][rd_idx];
  assign rd_strb = strb_q[rd_buf][rd_idx];

endmodule

// File: rtl/wmb_lru.sv
module wmb_lru #(
  parameter int NBUF = 4,
  parameter int BW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [BW-1:0] touch_id,
  output logic [BW-1:0] lru_id
);

  // rank 0 = most recently used, NBUF-1 = least recently used
  logic [BW-1:0] rank_q [NBUF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NBUF; j++) rank_q[j] <= BW'(j);
    end else if (touch_en) begin
      for (int j = 0; j < NBUF; j++) begin
        if (BW'(j) == touch_id)
          rank_q[j] <= '0;
        else if (rank_q[j] < rank_q[touch_id])
          rank_q[j] <= rank_q[j] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_id = '0;
    for (int j = 0; j < NBUF; j++) begin
      if (rank_q[j] == BW'(NBUF - 1)) lru_id = BW'(j);
    end
  end

endmodule

// File: rtl/wmb_ctrl.sv
module wmb_ctrl
  import wmb_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int WORDS = 16,
  parameter int AW    = 16,
  parameter int BW    = 2,
  parameter int IW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_enable,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  word_t           req_wdata,
  input  lane_t           req_strb,
  output logic            req_ack,
  output word_t           req_rdata,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output word_t           mem_wdata,
  output lane_t           mem_strb,
  input  logic            mem_ready,
  input  word_t           mem_rdata,
  output logic            flush_done,
  // line store port
  output logic            st_merge,
  output logic            st_fill,
  output logic [BW-1:0]   st_wbuf,
  output logic [IW-1:0]   st_widx,
  output word_t           st_wdata,
  output logic            st_clr,
  output logic [BW-1:0]   st_cbuf,
  output logic [BW-1:0]   st_rbuf,
  output logic [IW-1:0]   st_ridx,
  input  word_t           st_rdata,
  input  lane_t           st_rstrb,
  // replacement port
  output logic            lru_touch,
  output logic [BW-1:0]   lru_tid,
  input  logic [BW-1:0]   lru_id,
  // observation
  output logic [NBUF-1:0] valid_vec,
  output logic [NBUF-1:0] hit_vec,
  output logic            in_flush,
  output logic            in_pass
);

  localparam int TW = AW - IW;

  state_e          state_q;
  logic [BW-1:0]   cur_q;
  logic [IW-1:0]   idx_q;
  word_t           rdata_q;
  logic [NBUF-1:0] valid_q, dirty_q, full_q;
  logic [TW-1:0]   tag_q [NBUF];

  logic [TW-1:0] req_tag;
  logic [IW-1:0] req_idx;
  assign req_tag = req_addr[AW-1:IW];
  assign req_idx = req_addr[IW-1:0];

  genvar g;
  generate
    for (g = 0; g < NBUF; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && (tag_q[g] == req_tag);
    end
  endgenerate

  logic [BW-1:0] hit_id, free_id, drain_id, victim;
  logic          hit, any_free, any_valid;

  always_comb begin
    hit_id   = '0;
    free_id  = '0;
    drain_id = '0;
    for (int b = 0; b < NBUF; b++)
      if (hit_vec[b]) hit_id = BW'(b);
    for (int b = NBUF - 1; b >= 0; b--) begin
      if (!valid_q[b]) free_id  = BW'(b);
      if (valid_q[b])  drain_id = BW'(b);
    end
  end

  assign hit       = |hit_vec;
  assign any_free  = ~&valid_q;
  assign any_valid = |valid_q;
  assign victim    = any_free ? free_id : lru_id;

  // named events
  logic serve_en, ev_wr_hit, ev_rd_full, ev_rd_part, ev_miss, ev_evict, ev_alloc;
  logic drain, drain_flush, drain_inval, byp_start;
  logic fill_beat, flush_beat, line_end;

  assign serve_en    = (state_q == ST_IDLE) && cfg_enable && req_valid;
  assign ev_wr_hit   = serve_en && hit && req_write;
  assign ev_rd_full  = serve_en && hit && !req_write && full_q[hit_id];
  assign ev_rd_part  = serve_en && hit && !req_write && !full_q[hit_id];
  assign ev_miss     = serve_en && !hit;
  assign ev_evict    = ev_miss && valid_q[victim] && dirty_q[victim];
  assign ev_alloc    = ev_miss && !ev_evict;
  assign drain       = (state_q == ST_IDLE) && !cfg_enable && any_valid;
  assign drain_flush = drain && dirty_q[drain_id];
  assign drain_inval = drain && !dirty_q[drain_id];
  assign byp_start   = (state_q == ST_IDLE) && !cfg_enable && !any_valid && req_valid;
  assign line_end    = (idx_q == IW'(WORDS - 1));
  assign fill_beat   = (state_q == ST_FILL) && mem_ready;
  assign flush_beat  = (state_q == ST_FLUSH) && ((st_rstrb == '0) || mem_ready);

  // line store control
  assign st_merge = ev_wr_hit || (ev_alloc && req_write);
  assign st_fill  = fill_beat;
  assign st_wbuf  = (state_q == ST_FILL) ? cur_q : (ev_alloc ? victim : hit_id);
  assign st_widx  = (state_q == ST_FILL) ? idx_q : req_idx;
  assign st_wdata = (state_q == ST_FILL) ? mem_rdata : req_wdata;
  assign st_clr   = ev_alloc || (flush_beat && line_end);
  assign st_cbuf  = (state_q == ST_FLUSH) ? cur_q : victim;
  assign st_rbuf  = (state_q == ST_IDLE) ? hit_id : cur_q;
  assign st_ridx  = (state_q == ST_IDLE || state_q == ST_PEEK) ? req_idx : idx_q;

  assign lru_touch = ev_wr_hit || ev_rd_full || ev_rd_part || ev_alloc;
  assign lru_tid   = ev_alloc ? victim : hit_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      idx_q   <= '0;
      rdata_q <= '0;
      valid_q <= '0;
      dirty_q <= '0;
      full_q  <= '0;
      for (int b = 0; b < NBUF; b++) tag_q[b] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ev_wr_hit) begin
            dirty_q[hit_id] <= 1'b1;
            state_q <= ST_ACK;
          end else if (ev_rd_full) begin
            rdata_q <= st_rdata;
            state_q <= ST_ACK;
          end else if (ev_rd_part) begin
            cur_q   <= hit_id;
            state_q <= ST_PEEK;
          end else if (ev_evict) begin
            cur_q   <= victim;
            idx_q   <= '0;
            state_q <= ST_FLUSH;
          end else if (ev_alloc) begin
            valid_q[victim] <= 1'b1;
            tag_q[victim]   <= req_tag;
            full_q[victim]  <= 1'b0;
            dirty_q[victim] <= req_write;
            if (req_write) begin
              state_q <= ST_ACK;
            end else begin
              cur_q   <= victim;
              idx_q   <= '0;
              state_q <= ST_FILL;
            end
          end else if (drain_flush) begin
            cur_q   <= drain_id;
            idx_q   <= '0;
            state_q <= ST_FLUSH;
          end else if (drain_inval) begin
            valid_q[drain_id] <= 1'b0;
            full_q[drain_id]  <= 1'b0;
          end else if (byp_start) begin
            state_q <= ST_PASS;
          end
        end
        ST_FLUSH: begin
          if (flush_beat) begin
            idx_q <= idx_q + 1'b1;
            if (line_end) begin
              dirty_q[cur_q] <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_FILL: begin
          if (fill_beat) begin
            idx_q <= idx_q + 1'b1;
            if (line_end) begin
              full_q[cur_q] <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_PEEK: begin
          if (mem_ready) begin
            rdata_q <= merge_lanes(mem_rdata, st_rdata, st_rstrb);
            state_q <= ST_ACK;
          end
        end
        ST_PASS: begin
          if (mem_ready) begin
            rdata_q <= mem_rdata;
            state_q <= ST_ACK;
          end
        end
        ST_ACK:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // back-end request
  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = {tag_q[cur_q], idx_q};
    mem_wdata = st_rdata;
    mem_strb  = '0;
    unique case (state_q)
      ST_FLUSH: begin
        mem_valid = (st_rstrb != '0);
        mem_write = 1'b1;
        mem_strb  = st_rstrb;
      end
      ST_FILL: mem_valid = 1'b1;
      ST_PEEK: begin
        mem_valid = 1'b1;
        mem_addr  = req_addr;
      end
      ST_PASS: begin
        mem_valid = 1'b1;
        mem_write = req_write;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
        mem_strb  = req_write ? req_strb : lane_t'(0);
      end
      default: ;
    endcase
  end

  assign req_ack    = (state_q == ST_ACK);
  assign req_rdata  = rdata_q;
  assign flush_done = !cfg_enable && !any_valid;
  assign valid_vec  = valid_q;
  assign in_flush   = (state_q == ST_FLUSH);
  assign in_pass    = (state_q == ST_PASS);

endmodule

// File: rtl/wmb_pool.sv
module wmb_pool
  import wmb_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int WORDS = 16,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [3:0]    req_strb,
  output logic          req_ack,
  output logic [31:0]   req_rdata,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_strb,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          flush_done
);

  localparam int BW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int IW = $clog2(WORDS);

  logic          st_merge, st_fill, st_clr;
  logic [BW-1:0] st_wbuf, st_cbuf, st_rbuf;
  logic [IW-1:0] st_widx, st_ridx;
  word_t         st_wdata, st_rdata;
  lane_t         st_rstrb;
  logic          lru_touch;
  logic [BW-1:0] lru_tid, lru_id;

  // observation wires for the checker
  logic [NBUF-1:0] chk_valid, chk_hit;
  logic            chk_flush, chk_pass;

  wmb_store #(.NBUF(NBUF), .WORDS(WORDS), .BW(BW), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .merge_en(st_merge), .fill_en(st_fill),
    .wr_buf(st_wbuf), .wr_idx(st_widx), .wr_data(st_wdata), .wr_strb(req_strb),
    .clr_en(st_clr), .clr_buf(st_cbuf),
    .rd_buf(st_rbuf), .rd_idx(st_ridx), .rd_data(st_rdata), .rd_strb(st_rstrb)
  );

  wmb_lru #(.NBUF(NBUF), .BW(BW)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(lru_touch), .touch_id(lru_tid), .lru_id(lru_id)
  );

  wmb_ctrl #(.NBUF(NBUF), .WORDS(WORDS), .AW(AW), .BW(BW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_strb(req_strb),
    .req_ack(req_ack), .req_rdata(req_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_strb(mem_strb),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .flush_done(flush_done),
    .st_merge(st_merge), .st_fill(st_fill), .st_wbuf(st_wbuf), .st_widx(st_widx),
    .st_wdata(st_wdata), .st_clr(st_clr), .st_cbuf(st_cbuf),
    .st_rbuf(st_rbuf), .st_ridx(st_ridx), .st_rdata(st_rdata), .st_rstrb(st_rstrb),
    .lru_touch(lru_touch), .lru_tid(lru_tid), .lru_id(lru_id),
    .valid_vec(chk_valid), .hit_vec(chk_hit),
    .in_flush(chk_flush), .in_pass(chk_pass)
  );

endmodule

// File: rtl/wmb_pool_chk.sv
module wmb_pool_chk #(
  parameter int NBUF = 4,
  parameter int AW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ack,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_write,
  input logic [AW-1:0]   mem_addr,
  input logic [3:0]      mem_strb,
  input logic            flush_done,
  input logic            in_flush,
  input logic            in_pass,
  input logic [NBUF-1:0] valid_vec,
  input logic [NBUF-1:0] hit_vec
);

  // R1
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_strb));

  // R7
  flush_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_flush && mem_valid |-> mem_write && (mem_strb != 4'b0000));

  // R7
  flush_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_flush && mem_valid && mem_ready |=> !(in_flush && mem_valid) || (mem_addr > $past(mem_addr)));

  // R8
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (valid_vec == '0));

  // R9
  pass_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_pass |-> (valid_vec == '0) && !in_flush);

  // R6
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

bind wmb_pool wmb_pool_chk #(.NBUF(NBUF), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_strb(mem_strb), .flush_done(flush_done),
  .in_flush(chk_flush), .in_pass(chk_pass),
  .valid_vec(chk_valid), .hit_vec(chk_hit)
);

// File: tb/wmb_pool_test.sv
module wmb_pool_test;

  localparam int AW    = 8;
  localparam int MSIZE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_enable = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [3:0]    req_strb = '0;
  logic          req_ack;
  logic [31:0]   req_rdata;
  logic          mem_valid, mem_write;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [3:0]    mem_strb;
  logic          mem_ready;
  logic          flush_done;

  wmb_pool #(.NBUF(4), .WORDS(16), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_strb(req_strb),
    .req_ack(req_ack), .req_rdata(req_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_strb(mem_strb),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .flush_done(flush_done)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0, rd_cnt = 0, ord_err = 0, zstrb_err = 0;
  int req_seq = 0, last_seq = -1;
  int last_wa = 0;
  int cyc_total = 0;
  bit stall_en = 1'b0;
  logic [7:0] stall_cnt = '0;
  logic [31:0] mem_arr [MSIZE];
  logic [31:0] ref_mem [MSIZE];

  function automatic logic [31:0] lane_mask(logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  function automatic logic [31:0] overlay(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    return (o & ~lane_mask(s)) | (n & lane_mask(s));
  endfunction

  assign mem_ready = !stall_en || stall_cnt[0];
  assign mem_rdata = mem_arr[mem_addr];

  // back-end memory model
  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 8'd1;
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        mem_arr[mem_addr] <= overlay(mem_arr[mem_addr], mem_wdata, mem_strb);
        wr_cnt++;
        if (mem_strb == 4'b0000) zstrb_err++;
        if (last_seq == req_seq && (int'(mem_addr) >> 4) == (last_wa >> 4) && int'(mem_addr) <= last_wa)
          ord_err++;
        last_wa  = int'(mem_addr);
        last_seq = req_seq;
      end else begin
        rd_cnt++;
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cyc_total);
      summary();
      $finish;
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input int addr, input logic [31:0] d,
                        input logic [3:0] s, output logic [31:0] rd, output int cyc);
    req_seq++;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr[AW-1:0];
    req_wdata = d;
    req_strb  = s;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!req_ack && cyc < 3000);
    rd = req_rdata;
    req_valid = 1'b0;
    if (!req_ack) begin
      errors++;
      $display("FAIL handshake actual no ack expected ack at addr %0h", addr);
    end
    if (wr) ref_mem[addr] = overlay(ref_mem[addr], d, s);
  endtask

  task automatic rd_chk(input int addr, input string req, output int cyc);
    logic [31:0] v;
    do_req(1'b0, addr, 32'h0, 4'h0, v, cyc);
    check(v == ref_mem[addr], req, v, ref_mem[addr]);
  endtask

  task automatic drain_wait(input string req);
    int n;
    @(negedge clk);
    cfg_enable = 1'b0;
    n = 0;
    while (!flush_done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    req_seq++;
    check(flush_done == 1'b1, req, flush_done, 1);
  endtask

  task automatic mem_compare(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < MSIZE; i++) if (mem_arr[i] !== ref_mem[i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    logic [31:0] v;
    int cyc, w0, r0;
    for (int i = 0; i < MSIZE; i++) begin
      mem_arr[i] = 32'hA5000000 ^ (i * 32'h01030507);
      ref_mem[i] = 32'hA5000000 ^ (i * 32'h01030507);
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ack == 1'b0, "R10 ack", req_ack, 0);
    check(mem_valid == 1'b0, "R10 mem_valid", mem_valid, 0);
    check(flush_done == 1'b0, "R10 flush_done", flush_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_valid == 1'b0 && req_ack == 1'b0, "R10 idle after reset", mem_valid, 0);

    // R1 / R2: merge writes into line 1, skipping every third word
    for (int w = 0; w < 16; w++) begin
      if (w % 3 != 2) begin
        do_req(1'b1, 16 + w, 32'h11111111 * (w + 1), 4'((w % 15) + 1), v, cyc);
        check(cyc == 1, "R1 write ack latency", cyc, 1);
      end
    end
    do_req(1'b1, 16 + 3, 32'hCAFEF00D, 4'b0011, v, cyc);
    check(cyc == 1, "R2 overlay write latency", cyc, 1);
    check(wr_cnt == 0 && rd_cnt == 0, "R2 no backend traffic", wr_cnt + rd_cnt, 0);

    // R5: reads of a partly written line merge line bytes over memory
    for (int w = 0; w < 16; w++) begin
      rd_chk(16 + w, "R5 merged read", cyc);
      check(cyc == 2, "R5 merged read latency", cyc, 2);
    end

    // R4: read miss on line 2 fills the whole line
    r0 = rd_cnt;
    rd_chk(32 + 5, "R4 fill data", cyc);
    check(cyc == 18, "R4 fill latency", cyc, 18);
    check(rd_cnt - r0 == 16, "R4 fill beats", rd_cnt - r0, 16);
    // R3: hits on the filled line
    r0 = rd_cnt;
    for (int w = 0; w < 16; w++) begin
      rd_chk(32 + w, "R3 hit data", cyc);
      check(cyc == 1, "R3 hit latency", cyc, 1);
    end
    check(rd_cnt == r0, "R3 no backend reads", rd_cnt - r0, 0);

    // R6: free buffers first, then LRU with write-back
    w0 = wr_cnt;
    do_req(1'b1, 48, 32'h30303030, 4'b1111, v, cyc);
    do_req(1'b1, 64, 32'h40404040, 4'b0101, v, cyc);
    check(wr_cnt == w0, "R6 free allocation no writeback", wr_cnt - w0, 0);
    do_req(1'b1, 80 + 2, 32'h50505050, 4'b1000, v, cyc);
    // R7: evicted line 1 wrote exactly its 11 strobed words, ascending
    check(wr_cnt - w0 == 11, "R7 flush word count", wr_cnt - w0, 11);
    check(ord_err == 0, "R7 ascending flush", ord_err, 0);
    check(zstrb_err == 0, "R7 strobed words only", zstrb_err, 0);
    for (int w = 0; w < 16; w++)
      check(mem_arr[16 + w] == ref_mem[16 + w], "R7 flushed contents", mem_arr[16 + w], ref_mem[16 + w]);
    rd_chk(32, "R6 touch line 2", cyc);
    w0 = wr_cnt;
    do_req(1'b1, 96, 32'h60606060, 4'b1111, v, cyc);
    check(wr_cnt - w0 == 1, "R6 LRU victim writes", wr_cnt - w0, 1);
    check(last_wa == 48, "R6 LRU victim is line 3", last_wa, 48);

    // R8: disable drains everything
    drain_wait("R8 flush_done set");
    mem_compare("R8 memory after drain");

    // R9: pass-through
    w0 = wr_cnt;
    do_req(1'b1, 200, 32'h9A9B9C9D, 4'b0110, v, cyc);
    check(cyc == 2, "R9 bypass write latency", cyc, 2);
    check(wr_cnt - w0 == 1, "R9 bypass write count", wr_cnt - w0, 1);
    check(mem_arr[200] == ref_mem[200], "R9 bypass write data", mem_arr[200], ref_mem[200]);
    r0 = rd_cnt;
    rd_chk(201, "R9 bypass read data", cyc);
    check(cyc == 2 && rd_cnt - r0 == 1, "R9 bypass read latency", cyc, 2);
    check(flush_done == 1'b1, "R8 flush_done holds", flush_done, 1);

    // sweep with a throttled back end (R2 R5 R6 R11)
    @(negedge clk);
    cfg_enable = 1'b1;
    stall_en = 1'b1;
    @(negedge clk);
    check(flush_done == 1'b0, "R8 flush_done clears", flush_done, 0);
    for (int i = 0; i < 480; i++) begin
      int a;
      a = ((i * 7) % 8) * 16 + ((i * 5 + (i >> 4)) % 16);
      if (i % 3 != 0)
        do_req(1'b1, a, 32'h9E3779B1 * (i + 1), 4'((i % 15) + 1), v, cyc);
      else
        rd_chk(a, "R2 sweep read", cyc);
    end
    drain_wait("R8 sweep drain");
    mem_compare("R8 sweep memory");
    check(ord_err == 0 && zstrb_err == 0, "R7 sweep flush rules", ord_err + zstrb_err, 0);

    summary();
    $finish;
  end

endmodule